// File: doc/BRIEF.md
# Packed Lane Integer ALU with Per-Lane Flags

This block is a single-cycle-latency SIMD integer unit for a 64-bit data path. Each operation splits both operands into byte, halfword or word lanes, selected by a size input, and works on every lane on its own. It can compare for equality or signed/unsigned greater-than, pick the signed/unsigned minimum or maximum, add or subtract with wraparound, and average byte or halfword lanes with an optional rounding increment.

Along with the 64-bit result, the unit builds a 32-bit flag word. Each lane has one 4-bit group in that word, and the group's position scales with the lane width. Each group holds a negative bit and a zero bit. The carry and overflow positions always read zero. The result and the flag word are registered together. A one-cycle strobe marks each new pair so the flag register beside the unit can be written.

Top module: `lane_simd_alu`

## Requirements
- R1: Compare ops write all ones into a lane when the relation holds and all zeros otherwise. The codes are op_sel 0 for equal, 1 for signed greater-than and 2 for unsigned greater-than, each comparing A against B.
- R2: Min/max ops take the whole lane from A when the relation holds and from B otherwise. The codes are op_sel 3 for signed min (A<B), 4 for unsigned min, 5 for signed max (A>B) and 6 for unsigned max.
- R3: op_sel 7 computes A+B and op_sel 8 computes A-B, each modulo the lane width. No carry or borrow crosses into a neighbouring lane.
- R4: op_sel 9 averages each lane as (A+B+round_in)>>1, keeping the carry bit. It is defined for size_sel 0 (8-bit lanes) and 1 (16-bit lanes). With size_sel 2 (32-bit lanes) it yields a zero result and a zero flag word.
- R5: The flag group of byte lane i sits at bits 4i+3..4i, of halfword lane i at bits 8i+7..8i+4, and of word lane i at bits 16i+15..16i+12. Within a group, bit 3 is negative, bit 2 is zero, and bits 1 and 0 (carry, overflow) always read 0. Bits outside the active groups read 0.
- R6: For ops 0 to 8, a lane's negative bit equals the lane's most significant result bit. Its zero bit is set exactly when all bits of the result lane are 0.
- R7: The average op sets only zero bits. Every negative bit is 0.
- R8: res_data and flag_data show the outcome of an op one clock after op_valid is sampled high. flag_we is high in exactly that cycle and low after a cycle without op_valid.
- R9: While op_valid is low, res_data and flag_data keep their values whatever the other inputs do.
- R10: Op codes 10 to 15, or size_sel 3, produce a zero result and a zero flag word.
- R11: During and right after reset, res_data, flag_data and flag_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_sel | input | 4 | Operation code (see R1 to R4, R10) |
| size_sel | input | 2 | Lane width: 0 byte, 1 halfword, 2 word, 3 undefined |
| round_in | input | 1 | Rounding increment for averaging |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| res_data | output | 64 | Registered lane result |
| flag_data | output | 32 | Registered per-lane flag word |
| flag_we | output | 1 | One-cycle strobe marking a new result and flag word |

## Verification
On every cycle, the assertions check the strobe timing and the hold behaviour. They also check that the carry and overflow positions stay clear, that no negative bit follows an average, and that a byte compare yields only 00 or FF lanes. They further check that byte min/max picks one operand's byte and that the lowest zero bit agrees with the result. Arithmetic correctness is shown only by the bench's sweeps: every op code across all four sizes and both rounding values, over corner and pseudo-random operands. The same applies to flag placement for halfword and word lanes, signed against unsigned ordering, and lane isolation of carries.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

   typedef enum logic [3:0] {
      OP_CMPEQ  = 4'd0,
      OP_CMPGTS = 4'd1,
      OP_CMPGTU = 4'd2,
      OP_MINS   = 4'd3,
      OP_MINU   = 4'd4,
      OP_MAXS   = 4'd5,
      OP_MAXU   = 4'd6,
      OP_ADD    = 4'd7,
      OP_SUB    = 4'd8,
      OP_AVG    = 4'd9
   } alu_op_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   // Bit offsets inside one 4-bit flag group
   localparam int FL_NEG  = 3;
   localparam int FL_ZERO = 2;
   localparam int FL_CARY = 1;
   localparam int FL_OVFL = 0;
   localparam int FL_GRP  = 4;

endpackage

// File: rtl/lane_unit.sv
module lane_unit
   import lane_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit AVG_EN = 1'b1
) (
   input  logic [3:0]   op_i,
   input  logic         rnd_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o,
   output logic         neg_o,
   output logic         zero_o
);

   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic         gt_s, gt_u, lt_s, lt_u, legal;
   logic [W:0]   avg_sum;

   assign gt_s    = $signed(a_i) > $signed(b_i);
   assign lt_s    = $signed(a_i) < $signed(b_i);
   assign gt_u    = a_i > b_i;
   assign lt_u    = a_i < b_i;
   assign avg_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, rnd_i};

   always_comb begin
      legal = 1'b1;
      res_o = '0;
      case (op_i)
         OP_CMPEQ:  res_o = (a_i == b_i) ? ONES : '0;
         OP_CMPGTS: res_o = gt_s ? ONES : '0;
         OP_CMPGTU: res_o = gt_u ? ONES : '0;
         OP_MINS:   res_o = lt_s ? a_i : b_i;
         OP_MINU:   res_o = lt_u ? a_i : b_i;
         OP_MAXS:   res_o = gt_s ? a_i : b_i;
         OP_MAXU:   res_o = gt_u ? a_i : b_i;
         OP_ADD:    res_o = a_i + b_i;
         OP_SUB:    res_o = a_i - b_i;
         OP_AVG: begin
            if (AVG_EN) res_o = avg_sum[W:1];
            else        legal = 1'b0;
         end
         default:   legal = 1'b0;
      endcase
   end

   assign neg_o  = legal && (op_i != OP_AVG) && res_o[W-1];
   assign zero_o = legal && (res_o == '0);

endmodule

// File: rtl/lane_group.sv
module lane_group
   import lane_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8,
   parameter int UNITS  = 1,
   parameter bit AVG_EN = 1'b1
) (
   input  logic [3:0]                         op_i,
   input  logic                               rnd_i,
   input  logic [DATA_W-1:0]                  a_i,
   input  logic [DATA_W-1:0]                  b_i,
   output logic [DATA_W-1:0]                  res_o,
   output logic [FL_GRP*(DATA_W/BYTE_W)-1:0]  flg_o
);

   localparam int LANE_W = BYTE_W * UNITS;
   localparam int NLANES = DATA_W / LANE_W;
   localparam int FLAG_W = FL_GRP * (DATA_W / BYTE_W);

   logic [NLANES-1:0] neg_v, zero_v;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      lane_unit #(.W(LANE_W), .AVG_EN(AVG_EN)) u_lane (
         .op_i   (op_i),
         .rnd_i  (rnd_i),
         .a_i    (a_i[i*LANE_W +: LANE_W]),
         .b_i    (b_i[i*LANE_W +: LANE_W]),
         .res_o  (res_o[i*LANE_W +: LANE_W]),
         .neg_o  (neg_v[i]),
         .zero_o (zero_v[i])
      );
   end

   // The group of a wide lane sits in the top byte-slot it covers.
   always_comb begin
      flg_o = '0;
      for (int i = 0; i < NLANES; i++) begin
         flg_o[FL_GRP*((i+1)*UNITS-1) + FL_NEG]  = neg_v[i];
         flg_o[FL_GRP*((i+1)*UNITS-1) + FL_ZERO] = zero_v[i];
      end
   end

   if (FLAG_W != FL_GRP * NLANES * UNITS) begin : g_bad_layout
      $error("lane_group: lanes do not tile the flag word");
   end

endmodule

// File: rtl/lane_simd_alu.sv
module lane_simd_alu
   import lane_alu_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int BYTE_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [3:0]           op_sel,
   input  logic [1:0]           size_sel,
   input  logic                 round_in,
   input  logic [DATA_W-1:0]    opa,
   input  logic [DATA_W-1:0]    opb,
   output logic [DATA_W-1:0]    res_data,
   output logic [FL_GRP*(DATA_W/BYTE_W)-1:0] flag_data,
   output logic                 flag_we
);

   localparam int NBYTES = DATA_W / BYTE_W;
   localparam int FLAG_W = FL_GRP * NBYTES;
   localparam int NSIZES = 3;

   if (DATA_W % (4 * BYTE_W) != 0) begin : g_bad_width
      $error("lane_simd_alu: DATA_W must hold a whole number of word lanes");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("lane_simd_alu: BYTE_W too small");
   end

   logic [DATA_W-1:0] res_g [NSIZES];
   logic [FLAG_W-1:0] flg_g [NSIZES];
   logic [DATA_W-1:0] res_nxt;
   logic [FLAG_W-1:0] flg_nxt;

   for (genvar s = 0; s < NSIZES; s++) begin : g_size
      lane_group #(
         .DATA_W (DATA_W),
         .BYTE_W (BYTE_W),
         .UNITS  (1 << s),
         .AVG_EN (s < 2)
      ) u_grp (
         .op_i  (op_sel),
         .rnd_i (round_in),
         .a_i   (opa),
         .b_i   (opb),
         .res_o (res_g[s]),
         .flg_o (flg_g[s])
      );
   end

   always_comb begin
      res_nxt = '0;
      flg_nxt = '0;
      case (size_sel)
         SZ_BYTE: begin res_nxt = res_g[0]; flg_nxt = flg_g[0]; end
         SZ_HALF: begin res_nxt = res_g[1]; flg_nxt = flg_g[1]; end
         SZ_WORD: begin res_nxt = res_g[2]; flg_nxt = flg_g[2]; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_data  <= '0;
         flag_data <= '0;
         flag_we   <= 1'b0;
      end else begin
         flag_we <= op_valid;
         if (op_valid) begin
            res_data  <= res_nxt;
            flag_data <= flg_nxt;
         end
      end
   end

   // ---------------- assertion helpers ----------------
   function automatic logic [FLAG_W-1:0] grp_mask(input int pos);
      logic [FLAG_W-1:0] m;
      m = '0;
      for (int g = 0; g < NBYTES; g++) m[FL_GRP*g + pos] = 1'b1;
      return m;
   endfunction

   localparam logic [FLAG_W-1:0] NEG_MASK = grp_mask(FL_NEG);
   localparam logic [FLAG_W-1:0] CV_MASK  = grp_mask(FL_CARY) | grp_mask(FL_OVFL);

   function automatic logic bytes_are_masks(input logic [DATA_W-1:0] d);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NBYTES; i++)
         if (d[i*BYTE_W +: BYTE_W] != '0 && d[i*BYTE_W +: BYTE_W] != {BYTE_W{1'b1}})
            ok = 1'b0;
      return ok;
   endfunction

   function automatic logic bytes_picked(input logic [DATA_W-1:0] d,
                                         input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NBYTES; i++)
         if (d[i*BYTE_W +: BYTE_W] != a[i*BYTE_W +: BYTE_W] &&
             d[i*BYTE_W +: BYTE_W] != b[i*BYTE_W +: BYTE_W])
            ok = 1'b0;
      return ok;
   endfunction

   a_r8_we_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> flag_we);

   a_r8_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !flag_we);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(res_data) && $stable(flag_data)));

   a_r5_no_carry_ovfl: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> ((flag_data & CV_MASK) == '0));

   a_r7_avg_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_AVG) |=> ((flag_data & NEG_MASK) == '0));

   a_r1_byte_cmp_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && size_sel == SZ_BYTE &&
       (op_sel == OP_CMPEQ || op_sel == OP_CMPGTS || op_sel == OP_CMPGTU))
      |=> bytes_are_masks(res_data));

   a_r2_byte_minmax_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && size_sel == SZ_BYTE && op_sel >= OP_MINS && op_sel <= OP_MAXU)
      |=> bytes_picked(res_data, $past(opa), $past(opb)));

   a_r6_lane0_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && size_sel == SZ_BYTE && op_sel <= OP_AVG)
      |=> (flag_data[FL_ZERO] == (res_data[BYTE_W-1:0] == '0)));

endmodule

// File: tb/lane_simd_alu_tb.sv
module lane_simd_alu_tb;

   localparam int CLK_P  = 10;
   localparam int NVEC   = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_sel = '0;
   logic [1:0]  size_sel = '0;
   logic        round_in = 1'b0;
   logic [63:0] opa = '0, opb = '0;
   logic [63:0] res_data;
   logic [31:0] flag_data;
   logic        flag_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lane_simd_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
      .size_sel(size_sel), .round_in(round_in), .opa(opa), .opb(opb),
      .res_data(res_data), .flag_data(flag_data), .flag_we(flag_we)
   );

   task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reference model, built from the requirements
   task automatic model(input logic [3:0] op, input logic [1:0] sz, input logic rnd,
                        input logic [63:0] a, input logic [63:0] b,
                        output logic [63:0] r, output logic [31:0] f);
      longint unsigned w, mask, sbit, la, lb, sa, sb, lr;
      int n, k, g;
      r = '0; f = '0;
      if (sz == 2'd3 || op > 4'd9 || (op == 4'd9 && sz == 2'd2)) return;
      w    = 64'd8 << sz;
      n    = 64 / int'(w);
      k    = int'(w) / 8;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
      sbit = 64'd1 << (w - 1);
      for (int i = 0; i < n; i++) begin
         la = (a >> (i * int'(w))) & mask;
         lb = (b >> (i * int'(w))) & mask;
         sa = la ^ sbit;
         sb = lb ^ sbit;
         case (op)
            4'd0: lr = (la == lb) ? mask : 0;
            4'd1: lr = (sa > sb) ? mask : 0;
            4'd2: lr = (la > lb) ? mask : 0;
            4'd3: lr = (sa < sb) ? la : lb;
            4'd4: lr = (la < lb) ? la : lb;
            4'd5: lr = (sa > sb) ? la : lb;
            4'd6: lr = (la > lb) ? la : lb;
            4'd7: lr = (la + lb) & mask;
            4'd8: lr = (la - lb) & mask;
            default: lr = (la + lb + longint'(rnd)) >> 1;
         endcase
         r = r | (lr << (i * int'(w)));
         g = (i + 1) * k - 1;
         f[4*g+3] = (op != 4'd9) && ((lr & sbit) != 0);
         f[4*g+2] = (lr == 0);
      end
   endtask

   function automatic logic [63:0] vec(input int v);
      case (v)
         0: return 64'h0;
         1: return '1;
         2: return 64'h8080_8080_8080_8080;
         3: return 64'h7F7F_7F7F_7F7F_7F7F;
         4: return 64'h8000_0000_8000_0000;
         5: return 64'h0001_0001_0001_0001;
         6: return 64'hFF00_FF00_00FF_00FF;
         7: return 64'h7FFF_FFFF_8000_0001;
         default: return (64'h9E37_79B9_7F4A_7C15 * 64'(v)) ^ (64'hC2B2_AE3D_27D4_EB4F >> (v % 13));
      endcase
   endfunction

   function automatic string req_res(input logic [3:0] op, input logic [1:0] sz);
      if (sz == 2'd3 || op > 4'd9) return "R10";
      if (op <= 4'd2) return "R1";
      if (op <= 4'd6) return "R2";
      if (op <= 4'd8) return "R3";
      return "R4";
   endfunction

   function automatic string req_flg(input logic [3:0] op, input logic [1:0] sz);
      if (sz == 2'd3 || op > 4'd9) return "R10";
      if (op == 4'd9) return "R7";
      return "R6";
   endfunction

   logic [63:0] last_r;
   logic [31:0] last_f;

   task automatic do_op(input logic [3:0] op, input logic [1:0] sz, input logic rnd,
                        input logic [63:0] a, input logic [63:0] b);
      logic [63:0] er;
      logic [31:0] ef;
      model(op, sz, rnd, a, b, er, ef);
      @(negedge clk);
      op_valid = 1'b1; op_sel = op; size_sel = sz; round_in = rnd; opa = a; opb = b;
      @(negedge clk);
      op_valid = 1'b0;
      check64(req_res(op, sz), res_data, er);
      check64(req_flg(op, sz), {32'h0, flag_data}, {32'h0, ef});
      check64("R8 strobe", {63'h0, flag_we}, 64'h1);
      last_r = er;
      last_f = ef;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check64("R11 result", res_data, 64'h0);
      check64("R11 flags", {32'h0, flag_data}, 64'h0);
      check64("R11 strobe", {63'h0, flag_we}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check64("R11 after release", {63'h0, flag_we}, 64'h0);

      // R5: directed flag placement
      do_op(4'd7, 2'd0, 1'b0, 64'h0, 64'h0);
      check64("R5 byte zero groups", {32'h0, flag_data}, 64'h4444_4444);
      do_op(4'd7, 2'd1, 1'b0, 64'h0, 64'h0);
      check64("R5 half zero groups", {32'h0, flag_data}, 64'h4040_4040);
      do_op(4'd7, 2'd2, 1'b0, 64'h0, 64'h0);
      check64("R5 word zero groups", {32'h0, flag_data}, 64'h4000_4000);
      do_op(4'd7, 2'd2, 1'b0, 64'h8000_0000_8000_0000, 64'h0);
      check64("R5 word negative groups", {32'h0, flag_data}, 64'h8000_8000);

      // R3: carry does not leak between lanes
      do_op(4'd7, 2'd0, 1'b0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001);
      check64("R3 byte wrap isolated", res_data, 64'h0000_0000_0000_0000);

      // R4: average keeps the carry
      do_op(4'd9, 2'd0, 1'b1, 64'hFF, 64'hFF);
      check64("R4 avg carry kept", res_data, 64'hFF);

      // R9 / R8: hold while idle, strobe drops
      do_op(4'd8, 2'd1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F);
      @(negedge clk);
      op_sel = 4'd0; opa = '1; opb = 64'h5; size_sel = 2'd2;
      check64("R8 strobe low", {63'h0, flag_we}, 64'h0);
      @(negedge clk);
      check64("R9 result held", res_data, last_r);
      check64("R9 flags held", {32'h0, flag_data}, {32'h0, last_f});

      // Sweep: every op code, every size, both rounding values
      for (int op = 0; op < 16; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int rn = 0; rn < 2; rn++)
               for (int v = 0; v < NVEC; v++) begin
                  logic [63:0] a, b;
                  a = vec(v);
                  b = (v % 5 == 0) ? a : vec((v * 7 + 3) % NVEC);
                  if (v % 5 == 1) b = a ^ 64'h0000_FF00_0000_0001;
                  do_op(op[3:0], sz[1:0], rn[0], a, b);
               end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule